// File: doc/BRIEF.md
# Pulse-and-Verify EPROM Programmer

This controller burns a range of addresses in a byte-wide UV-erasable memory. Software gives it a first and a last address and a start strobe. It then takes one target byte per address from a valid/ready stream. For each byte it fires short programming pulses on the chip-enable line, with the program supply switched on and the byte driven onto the data lines. After every short pulse it reads the location back at the program supply. As soon as the read-back matches, it fires one long over-program pulse. That pulse is three times the total short-pulse time this byte needed. Pulse widths are counted in clock cycles, and the count is derived from the clock frequency parameter.

An erased cell reads as one, so a target of all ones needs no pulse and that byte is skipped. A byte that still mismatches after the allowed number of short pulses is reported as failed, and the run stops. If every byte programs, the controller makes a second pass over the same range with the program supply off. In that pass the host streams the same bytes again, and each location is compared with its byte. Done and error flags report the outcome of the whole run.

Top module: `eprom_burner`

## Requirements
- R1: While reset is held, and while idle after reset, memCeN and memOeN are high, memVppEn and memDataOe are low, and dataReady, busy, doneFlag and errFlag are low.
- R2: A short pulse holds memCeN low for exactly PULSE_CYC = CLK_HZ*PULSE_US/1000000 cycles. Throughout the pulse memOeN is high, memVppEn and memDataOe are high, and memWrData carries the target byte.
- R3: Between two pulses on the same address there is a verify read. During that read memOeN is low, memCeN is high, memVppEn is high and memDataOe is low. Short pulses repeat while memRdData differs from the target.
- R4: After the verify that matches, exactly one over-program pulse follows. It holds memCeN low for OVER_MULT*n*PULSE_CYC cycles, where n is the number of short pulses the byte needed. It is then followed by no further pulse on that address.
- R5: memAddr, memWrData, memVppEn and memDataOe hold their values for one cycle before memCeN falls for a programming pulse. They also hold for the cycle in which memCeN rises again.
- R6: A target byte of all ones (8'hFF) gets no pulse. It is reported with byteDone and byteOk high.
- R7: If the verify still mismatches after MAX_TRIES short pulses, the controller pulses byteDone with byteOk low. It then fires no more pulses and ends the run with errFlag and doneFlag high. A byte that matches after exactly MAX_TRIES pulses still succeeds.
- R8: After the last address has programmed, every address of the range is read again with memVppEn low and both memCeN and memOeN low. A mismatch between memRdData and the re-streamed byte sets errFlag.
- R9: A byte is accepted on a clock edge where dataValid and dataReady are both high. Exactly one byte is taken per address in the programming pass, and one per address in the final pass. dataReady is low whenever no byte is awaited.
- R10: byteDone is a single-cycle pulse, given once per address in the programming pass. The addresses are served in ascending order from startAddr to endAddr inclusive.
- R11: doneFlag rises at the end of every run, and busy is low again in the cycle after. Both flags stay set until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| startAddr | input | ADDR_W | First address of the range |
| endAddr | input | ADDR_W | Last address of the range |
| dataValid | input | 1 | Stream byte is valid |
| dataIn | input | DATA_W | Stream byte |
| dataReady | output | 1 | Controller awaits a byte |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | DATA_W | Byte driven to the memory data lines |
| memDataOe | output | 1 | Drive memWrData onto the data lines |
| memCeN | output | 1 | Chip enable, active low (programming pulse) |
| memOeN | output | 1 | Output enable, active low (read) |
| memVppEn | output | 1 | Switch program supply to programming level |
| memRdData | input | DATA_W | Byte read from the memory |
| busy | output | 1 | Run in progress |
| byteDone | output | 1 | One address finished in programming pass |
| byteOk | output | 1 | Qualifies byteDone: byte programmed or skipped |
| doneFlag | output | 1 | Run finished |
| errFlag | output | 1 | A byte failed or final read mismatched |

## Verification
The bench's memory model lets each address need its own number of pulses before its bits clear. The pulse counts covered are one, several, exactly the limit, and one above the limit. A design with an off-by-one try limit would fail the byte that needs exactly the limit, or would add a 26th pulse. A design that scaled the over-program pulse wrongly would show the wrong low time on the chip-enable line at the long pulse. An all-ones byte must produce no pulse at all. A controller that burned it anyway would show an extra pulse on the chip-enable line. The final pass is fed one altered byte, and a controller that skipped the compare would finish without the error flag. The bench also streams with gaps, to catch a design that takes a byte without a handshake.

// File: rtl/burn_pkg.sv
`timescale 1ns/1ps
package burn_pkg;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic ldRange;
    logic ldData;
    logic incAddr;
    logic rewind;
    logic clrTries;
    logic incTries;
    logic ldTimer;
    logic decTimer;
    logic setOver;
    logic clrOver;
  } burn_strobe_t;

  // conditions from datapath to sequencer
  typedef struct packed {
    logic dataBlank;
    logic lastAddr;
    logic triesMax;
    logic timerLast;
    logic readMatch;
    logic overPhase;
  } burn_status_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_VREAD, S_VCMP,
    S_NEXT, S_FAIL, S_RFETCH, S_RREAD, S_RCMP, S_FINISH
  } burn_state_t;

endpackage

// File: rtl/burn_dp.sv
`timescale 1ns/1ps
module burn_dp
  import burn_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int MAX_TRIES = 25,
  parameter int OVER_MULT = 3,
  parameter int PULSE_CYC = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  burn_strobe_t      sb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] memRdData,
  output burn_status_t      st,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);

  localparam int    TRY_W    = $clog2(MAX_TRIES + 1);
  localparam longint OVER_MAX = longint'(MAX_TRIES) * OVER_MULT * PULSE_CYC;
  localparam int    TMR_W    = $clog2(OVER_MAX + 1);
  localparam logic [TMR_W-1:0] PULSE_T = TMR_W'(PULSE_CYC);
  localparam logic [TMR_W-1:0] OVER_T  = TMR_W'(longint'(OVER_MULT) * PULSE_CYC);

  logic [ADDR_W-1:0] addrQ, firstQ, lastQ;
  logic [DATA_W-1:0] dataQ;
  logic [TRY_W-1:0]  tries;
  logic [TMR_W-1:0]  timer;
  logic              overQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      firstQ <= '0;
      lastQ  <= '0;
      dataQ  <= '0;
      tries  <= '0;
      timer  <= '0;
      overQ  <= 1'b0;
    end else begin
      if (sb.ldRange) begin
        addrQ  <= startAddr;
        firstQ <= startAddr;
        lastQ  <= endAddr;
      end else if (sb.rewind) begin
        addrQ <= firstQ;
      end else if (sb.incAddr) begin
        addrQ <= addrQ + 1'b1;
      end

      if (sb.ldData) dataQ <= dataIn;

      if (sb.clrTries)      tries <= '0;
      else if (sb.incTries) tries <= tries + 1'b1;

      if (sb.ldTimer)       timer <= overQ ? TMR_W'(tries) * OVER_T : PULSE_T;
      else if (sb.decTimer) timer <= timer - 1'b1;

      if (sb.clrOver)      overQ <= 1'b0;
      else if (sb.setOver) overQ <= 1'b1;
    end
  end

  always_comb begin
    st.dataBlank = &dataIn;
    st.lastAddr  = (addrQ == lastQ);
    st.triesMax  = (tries == TRY_W'(MAX_TRIES));
    st.timerLast = (timer == TMR_W'(1));
    st.readMatch = (memRdData == dataQ);
    st.overPhase = overQ;
  end

  assign memAddr   = addrQ;
  assign memWrData = dataQ;

endmodule

// File: rtl/burn_ctrl.sv
`timescale 1ns/1ps
module burn_ctrl
  import burn_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         dataValid,
  input  burn_status_t st,
  output burn_strobe_t sb,
  output logic         dataReady,
  output logic         memCeN,
  output logic         memOeN,
  output logic         memVppEn,
  output logic         memDataOe,
  output logic         busy,
  output logic         byteDone,
  output logic         byteOk,
  output logic         doneFlag,
  output logic         errFlag
);

  burn_state_t state, nxt;

  always_comb begin
    nxt       = state;
    sb        = '0;
    dataReady = 1'b0;
    memCeN    = 1'b1;
    memOeN    = 1'b1;
    memVppEn  = 1'b0;
    memDataOe = 1'b0;
    byteDone  = 1'b0;
    byteOk    = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        sb.ldRange = 1'b1;
        nxt = S_FETCH;
      end
      S_FETCH: begin
        dataReady = 1'b1;
        if (dataValid) begin
          sb.ldData   = 1'b1;
          sb.clrTries = 1'b1;
          sb.clrOver  = 1'b1;
          nxt = st.dataBlank ? S_NEXT : S_SETUP;
        end
      end
      S_SETUP: begin
        memVppEn    = 1'b1;
        memDataOe   = 1'b1;
        sb.ldTimer  = 1'b1;
        sb.incTries = !st.overPhase;
        nxt = S_PULSE;
      end
      S_PULSE: begin
        memCeN      = 1'b0;
        memVppEn    = 1'b1;
        memDataOe   = 1'b1;
        sb.decTimer = 1'b1;
        if (st.timerLast) nxt = S_HOLD;
      end
      S_HOLD: begin
        memVppEn  = 1'b1;
        memDataOe = 1'b1;
        nxt = st.overPhase ? S_NEXT : S_VREAD;
      end
      S_VREAD: begin
        memVppEn = 1'b1;
        memOeN   = 1'b0;
        nxt = S_VCMP;
      end
      S_VCMP: begin
        memVppEn = 1'b1;
        memOeN   = 1'b0;
        if (st.readMatch) begin
          sb.setOver = 1'b1;
          nxt = S_SETUP;
        end else if (st.triesMax) begin
          nxt = S_FAIL;
        end else begin
          nxt = S_SETUP;
        end
      end
      S_NEXT: begin
        byteDone = 1'b1;
        byteOk   = 1'b1;
        if (st.lastAddr) begin
          sb.rewind = 1'b1;
          nxt = S_RFETCH;
        end else begin
          sb.incAddr = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_FAIL: begin
        byteDone = 1'b1;
        nxt = S_FINISH;
      end
      S_RFETCH: begin
        dataReady = 1'b1;
        if (dataValid) begin
          sb.ldData = 1'b1;
          nxt = S_RREAD;
        end
      end
      S_RREAD: begin
        memCeN = 1'b0;
        memOeN = 1'b0;
        nxt = S_RCMP;
      end
      S_RCMP: begin
        memCeN = 1'b0;
        memOeN = 1'b0;
        if (st.lastAddr) begin
          nxt = S_FINISH;
        end else begin
          sb.incAddr = 1'b1;
          nxt = S_RFETCH;
        end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
      end
      if (state == S_FAIL) errFlag <= 1'b1;
      if (state == S_RCMP && !st.readMatch) errFlag <= 1'b1;
      if (state == S_FINISH) doneFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/eprom_burner.sv
`timescale 1ns/1ps
module eprom_burner
  import burn_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_HZ    = 50000000,
  parameter int PULSE_US  = 1000,
  parameter int MAX_TRIES = 25,
  parameter int OVER_MULT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memDataOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memVppEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              byteDone,
  output logic              byteOk,
  output logic              doneFlag,
  output logic              errFlag
);

  localparam int PULSE_CYC = int'((longint'(CLK_HZ) * PULSE_US) / 1000000);

  burn_strobe_t sb;
  burn_status_t st;

  burn_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dataValid (dataValid),
    .st        (st),
    .sb        (sb),
    .dataReady (dataReady),
    .memCeN    (memCeN),
    .memOeN    (memOeN),
    .memVppEn  (memVppEn),
    .memDataOe (memDataOe),
    .busy      (busy),
    .byteDone  (byteDone),
    .byteOk    (byteOk),
    .doneFlag  (doneFlag),
    .errFlag   (errFlag)
  );

  burn_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_TRIES (MAX_TRIES),
    .OVER_MULT (OVER_MULT),
    .PULSE_CYC (PULSE_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sb        (sb),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .dataIn    (dataIn),
    .memRdData (memRdData),
    .st        (st),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/burn_chk.sv
`timescale 1ns/1ps
module burn_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              memDataOe,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memVppEn,
  input logic              busy,
  input logic              byteDone,
  input logic              byteOk,
  input logic              doneFlag,
  input logic              errFlag
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memCeN && memOeN && !memVppEn && !memDataOe && !dataReady));

  p_pulse_supply_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && memOeN) |-> (memVppEn && memDataOe));

  p_verify_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && memVppEn) |-> (memCeN && !memDataOe));

  p_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCeN) && memOeN) |-> ($stable(memAddr) && $stable(memWrData) && $past(memVppEn) && $past(memDataOe)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memCeN) && memVppEn) |-> ($stable(memAddr) && $stable(memWrData) && memDataOe));

  p_fail_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !byteOk) |=> errFlag);

  p_final_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && !memVppEn) |-> (!memCeN && !memDataOe));

  p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busy);

endmodule

bind eprom_burner burn_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dataReady (dataReady),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .memDataOe (memDataOe),
  .memCeN    (memCeN),
  .memOeN    (memOeN),
  .memVppEn  (memVppEn),
  .busy      (busy),
  .byteDone  (byteDone),
  .byteOk    (byteOk),
  .doneFlag  (doneFlag),
  .errFlag   (errFlag)
);

// File: tb/eprom_burner_bench.sv
`timescale 1ns/1ps
module eprom_burner_bench;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int PCYC  = 4;   // 4000 Hz * 1000 us
  localparam int MAXT  = 25;
  localparam int OMULT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] startAddr = '0, endAddr = '0;
  logic dataValid = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic dataReady, memDataOe, memCeN, memOeN, memVppEn;
  logic busy, byteDone, byteOk, doneFlag, errFlag;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData, memRdData;

  always #2.5 clk = ~clk;

  eprom_burner #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(4000), .PULSE_US(1000),
    .MAX_TRIES(MAXT), .OVER_MULT(OMULT)
  ) u_eprom_burner (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .endAddr(endAddr),
    .dataValid(dataValid), .dataIn(dataIn), .dataReady(dataReady),
    .memAddr(memAddr), .memWrData(memWrData), .memDataOe(memDataOe),
    .memCeN(memCeN), .memOeN(memOeN), .memVppEn(memVppEn), .memRdData(memRdData),
    .busy(busy), .byteDone(byteDone), .byteOk(byteOk), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  // memory model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int needTab [0:(1<<AW)-1];
  int pulseCnt[0:(1<<AW)-1];
  assign memRdData = mem[memAddr];

  int checks = 0, fails = 0;
  int expPulseQ[$];
  int expAddrQ[$];
  bit expOkQ[$];
  logic [DW-1:0] streamQ[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // stream driver with gaps
  int gapCnt = 0;
  bit feedTake = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (feedTake && streamQ.size() > 0) void'(streamQ.pop_front());
      gapCnt++;
      dataValid = (streamQ.size() > 0) && (gapCnt % 3 != 1);
      dataIn    = (streamQ.size() > 0) ? streamQ[0] : '0;
      feedTake  = dataValid && dataReady;
    end
  end

  // per-clock reference comparison
  logic prevCe = 1'b1, prevVpp = 1'b0, prevDoe = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevData = '0;
  bit progMode = 1'b0, verifySeen = 1'b0;
  int lowCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!memOeN && memVppEn && memCeN) verifySeen = 1'b1;
      if (prevCe && !memCeN) begin
        progMode = memOeN;
        lowCnt = 0;
        if (memOeN) begin
          check(memAddr == prevAddr && memWrData == prevData && prevVpp && prevDoe,
                "R5", "setup stability", int'(memAddr), int'(prevAddr));
          if (pulseCnt[memAddr] > 0)
            check(verifySeen, "R3", "verify before repeat pulse", int'(verifySeen), 1);
          verifySeen = 1'b0;
        end else begin
          check(!memVppEn, "R8", "final read supply level", int'(memVppEn), 0);
        end
      end
      if (!memCeN) begin
        lowCnt++;
        if (progMode)
          check(memVppEn && memDataOe && memOeN, "R2", "supply and data during pulse",
                int'(memVppEn && memDataOe), 1);
      end
      if (!prevCe && memCeN && progMode) begin
        check(memAddr == prevAddr && memWrData == prevData && memVppEn && memDataOe,
              "R5", "hold stability", int'(memAddr), int'(prevAddr));
        if (expPulseQ.size() == 0) begin
          check(1'b0, "R4", "unexpected pulse", lowCnt, 0);
        end else begin
          int e;
          e = expPulseQ.pop_front();
          check(lowCnt == e, "R2/R4", "pulse width", lowCnt, e);
        end
        pulseCnt[prevAddr]++;
        if (pulseCnt[prevAddr] >= needTab[prevAddr]) mem[prevAddr] = mem[prevAddr] & prevData;
        progMode = 1'b0;
      end
      if (byteDone) begin
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R10", "unexpected byteDone", int'(memAddr), -1);
        end else begin
          int ea;
          bit eo;
          ea = expAddrQ.pop_front();
          eo = expOkQ.pop_front();
          check(int'(memAddr) == ea, "R10", "byte order", int'(memAddr), ea);
          check(byteOk == eo, "R6/R7", "byteOk", int'(byteOk), int'(eo));
        end
      end
    end
    prevCe = memCeN; prevVpp = memVppEn; prevDoe = memDataOe;
    prevAddr = memAddr; prevData = memWrData;
  end

  task automatic runJob(int sa, int ea, logic [DW-1:0] prog[$], logic [DW-1:0] fin[$],
                        bit expErr, string req);
    bit failed = 1'b0;
    int n;
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = '1;
      pulseCnt[a] = 0;
    end
    for (int i = 0; i <= ea - sa; i++) begin
      expAddrQ.push_back(sa + i);
      streamQ.push_back(prog[i]);
      if (prog[i] == 8'hFF) begin
        expOkQ.push_back(1'b1);
      end else begin
        n = needTab[sa + i];
        if (n > MAXT) begin
          for (int k = 0; k < MAXT; k++) expPulseQ.push_back(PCYC);
          expOkQ.push_back(1'b0);
          failed = 1'b1;
          break;
        end
        for (int k = 0; k < n; k++) expPulseQ.push_back(PCYC);
        expPulseQ.push_back(OMULT * n * PCYC);
        expOkQ.push_back(1'b1);
      end
    end
    if (!failed) foreach (fin[i]) streamQ.push_back(fin[i]);
    @(negedge clk);
    startAddr = AW'(sa); endAddr = AW'(ea); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !doneFlag && !errFlag, "R11", "flags cleared at start", int'(doneFlag), 0);
    while (!doneFlag) @(negedge clk);
    check(!busy, "R11", "idle after done", int'(busy), 0);
    check(errFlag == expErr, req, "errFlag at end", int'(errFlag), int'(expErr));
    check(expPulseQ.size() == 0, "R4/R7", "missing pulses", expPulseQ.size(), 0);
    check(expAddrQ.size() == 0, "R10", "missing byteDone", expAddrQ.size(), 0);
    check(streamQ.size() == 0 && !dataReady, "R9", "stream fully consumed", streamQ.size(), 0);
    for (int i = 0; i <= ea - sa; i++) begin
      if (failed) break;
      check(mem[sa + i] == prog[i], "R2", "memory content", int'(mem[sa + i]), int'(prog[i]));
    end
    expPulseQ.delete(); expAddrQ.delete(); expOkQ.delete(); streamQ.delete();
    repeat (3) @(negedge clk);
    check(doneFlag && !busy && memCeN && !memVppEn, "R11", "flags hold after run",
          int'(doneFlag), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] p[$];
    logic [DW-1:0] f[$];
    for (int a = 0; a < (1 << AW); a++) begin
      needTab[a] = 1; mem[a] = '1; pulseCnt[a] = 0;
    end
    repeat (3) @(negedge clk);
    check(memCeN && memOeN && !memVppEn && !memDataOe, "R1", "memory controls in reset",
          int'({memCeN, memOeN, memVppEn, memDataOe}), 4'b1100);
    check(!dataReady && !busy && !doneFlag && !errFlag, "R1", "status in reset",
          int'({dataReady, busy, doneFlag, errFlag}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(memCeN && !memVppEn && !busy && !dataReady, "R1", "idle after reset",
          int'(busy), 0);

    // mixed pulse counts, one blank byte
    needTab[2] = 1; needTab[4] = 3; needTab[5] = 2; needTab[6] = 4; needTab[7] = 1;
    p = '{8'h5A, 8'hFF, 8'h00, 8'h81, 8'h3C, 8'hFE};
    runJob(2, 7, p, p, 1'b0, "R4");

    // single address needing exactly the limit
    needTab[10] = MAXT;
    p = '{8'h12};
    runJob(10, 10, p, p, 1'b0, "R7");

    // one byte over the limit aborts the run
    needTab[20] = 2; needTab[21] = MAXT + 1;
    p = '{8'h77, 8'h11, 8'h22, 8'h33};
    runJob(20, 23, p, p, 1'b1, "R7");

    // final pass mismatch
    needTab[30] = 1; needTab[31] = 2; needTab[32] = 1;
    p = '{8'hF0, 8'h0F, 8'hAA};
    f = '{8'hF0, 8'h0E, 8'hAA};
    runJob(30, 32, p, f, 1'b1, "R8");

    // all blank bytes: no pulses at all
    p = '{8'hFF, 8'hFF, 8'hFF};
    runJob(40, 42, p, p, 1'b0, "R6");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule